// File: doc/BRIEF.md
# Bipolar Line Code Violation Monitor

This block watches a dual-rail bipolar receive stream. One input carries positive pulses and the other carries negative pulses. Both are sampled only on cycles where a recovered-clock enable is high. Each sample is classed as a positive mark, a negative mark, or a space. The block keeps the polarity history that a line code rule needs. It raises four kinds of event: line code violations, valid HDB3 zero-substitution signatures, runs of four spaces, and changes in the loss-of-signal level.

Two select inputs choose the violation rule. Plain AMI mode treats any repeated polarity as an error. HDB3 mode accepts a repeated polarity only when it forms a proper substitution. Relaxed mode only checks that successive violations alternate in polarity. Events latch into an 8-bit status word. A single-cycle read strobe clears the latched events, and the strobe marks the cycle in which the processor takes the word.

Top module: `lcv_monitor`

## Requirements
- R1: The status word places the violation event at bit 7, the loss-of-signal change event at bit 6, the HDB3 signature event at bit 5, the four-space event at bit 4, and the live loss-of-signal level at bit 0. Bits 3 to 1 always read 0. All bits are 0 after reset.
- R2: Event bits 7 to 4 go high in the cycle after their event and hold until a cycle with `rd_stb` high clears them. An event arriving in the same cycle as `rd_stb` leaves its bit set after that cycle.
- R3: When `ami_sel`=1, a mark with the same polarity as the previous mark sets bit 7.
- R4: When `ami_sel`=0 and `relax_sel`=0 (HDB3 mode), a bipolar violation sets bit 7 if it has the same polarity as the previous bipolar violation, or if fewer than two spaces came before it. A bipolar violation is a mark with the same polarity as the previous mark.
- R5: When `ami_sel`=0 and `relax_sel`=1 (relaxed mode), bit 7 is set only when a bipolar violation has the same polarity as the previous bipolar violation.
- R6: In any mode, a bipolar violation that follows at least two spaces and is opposite in polarity to the previous bipolar violation sets bit 5.
- R7: Bit 4 is set when the fourth consecutive space is received. It is set only once for each run of spaces.
- R8: The loss-of-signal level (bit 0) goes to 1 when the 32nd consecutive space is received and goes to 0 on the next mark. Every change of this level, up or down, sets bit 6.
- R9: After reset, neither the first mark nor the first bipolar violation can set bit 7 or bit 5. They only load the polarity references.
- R10: A sample with both rails high counts as a space and leaves the polarity history unchanged.
- R11: Rail values on cycles where `sample_en` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Recovered-clock enable; rails are sampled when high |
| rail_pos | input | 1 | Positive-pulse rail |
| rail_neg | input | 1 | Negative-pulse rail |
| ami_sel | input | 1 | Selects the plain AMI rule; overrides `relax_sel` |
| relax_sel | input | 1 | Selects the relaxed rule when `ami_sel` is 0 |
| rd_stb | input | 1 | Status read strobe; clears the event bits |
| status | output | 8 | Interrupt status word |

## Verification
The embedded assertions check on every cycle that latched events survive until a read and clear on a read with no new event. They also check that a change in loss of signal always shows up in bit 6, that the space counter stays within bounds and agrees with the loss level, and that HDB3 mode never reports a violation and a signature for the same pulse. The polarity rules can only be shown by the bench's directed pulse sequences. These include the difference between AMI, HDB3 and relaxed rules on the same pattern, the quiet first violation after reset, both-rails samples, ignored samples, and the exact sample on which the four-space and 32-space events appear.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
   typedef enum logic [1:0] {
      RULE_AMI   = 2'd0,
      RULE_HDB3  = 2'd1,
      RULE_RELAX = 2'd2
   } lcv_rule_e;

   localparam int unsigned EV_NUM = 4;
   localparam int unsigned EV_LCV = 3;
   localparam int unsigned EV_LOS = 2;
   localparam int unsigned EV_SIG = 1;
   localparam int unsigned EV_Z4  = 0;
endpackage

// File: rtl/lcv_space_run.sv
module lcv_space_run #(
   parameter int unsigned ZERO_RUN   = 4,
   parameter int unsigned LOS_SPACES = 32,
   localparam int unsigned CNT_W     = $clog2(LOS_SPACES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             is_mark,
   output logic [CNT_W-1:0] run_len,
   output logic             z4_ev,
   output logic             los_q,
   output logic             los_chg
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOS_SPACES);
   localparam logic [CNT_W-1:0] Z_HIT   = CNT_W'(ZERO_RUN - 1);

   if (LOS_SPACES <= ZERO_RUN) begin : g_bad_cfg
      $error("lcv_space_run: LOS_SPACES must exceed ZERO_RUN");
   end

   logic [CNT_W-1:0] cnt_d;
   logic             los_d;
   logic             is_space;

   assign is_space = take && !is_mark;

   always_comb begin
      cnt_d = run_len;
      los_d = los_q;
      if (take) begin
         if (is_mark) begin
            cnt_d = '0;
            los_d = 1'b0;
         end else begin
            if (run_len != CNT_MAX) cnt_d = run_len + 1'b1;
            if (cnt_d == CNT_MAX) los_d = 1'b1;
         end
      end
   end

   assign z4_ev   = is_space && (run_len == Z_HIT);
   assign los_chg = los_d != los_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         los_q   <= 1'b0;
      end else begin
         run_len <= cnt_d;
         los_q   <= los_d;
      end
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= CNT_MAX);
   assert_los_means_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      los_q |-> (run_len == CNT_MAX));
   assert_mark_drops_los_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_mark) |=> !los_q);
endmodule

// File: rtl/lcv_polarity_track.sv
module lcv_polarity_track
   import lcv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      take,
   input  logic      is_mark,
   input  logic      mark_pos,
   input  logic      gap_ok,
   input  lcv_rule_e rule,
   output logic      lcv_ev,
   output logic      sig_ev
);
   logic have_mark, last_pos;
   logic have_bpv, bpv_pos;
   logic bpv, same_bpv;

   assign bpv      = take && is_mark && have_mark && (mark_pos == last_pos);
   assign same_bpv = have_bpv && (mark_pos == bpv_pos);

   always_comb begin
      lcv_ev = 1'b0;
      unique case (rule)
         RULE_AMI:   lcv_ev = bpv;
         RULE_HDB3:  lcv_ev = bpv && have_bpv && (same_bpv || !gap_ok);
         RULE_RELAX: lcv_ev = bpv && same_bpv;
         default:    lcv_ev = 1'b0;
      endcase
   end

   assign sig_ev = bpv && have_bpv && gap_ok && !same_bpv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_mark <= 1'b0;
         last_pos  <= 1'b0;
         have_bpv  <= 1'b0;
         bpv_pos   <= 1'b0;
      end else if (take && is_mark) begin
         have_mark <= 1'b1;
         last_pos  <= mark_pos;
         if (bpv) begin
            have_bpv <= 1'b1;
            bpv_pos  <= mark_pos;
         end
      end
   end

   assert_first_mark_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !have_mark |-> (!lcv_ev && !sig_ev));
   assert_hdb3_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rule == RULE_HDB3) |-> !(lcv_ev && sig_ev));
   assert_idle_no_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !take |-> (!lcv_ev && !sig_ev));
endmodule

// File: rtl/lcv_status_latch.sv
module lcv_status_latch #(
   parameter int unsigned NUM_EV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [NUM_EV-1:0] ev,
   output logic [NUM_EV-1:0] flags
);
   for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= ev[i] | (flags[i] & ~rd_stb);
      end

      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> flags[i]);
      assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && !ev[i]) |=> !flags[i]);
      assert_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !rd_stb) |=> flags[i]);
   end
endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
   import lcv_pkg::*;
#(
   parameter int unsigned ZERO_RUN   = 4,
   parameter int unsigned LOS_SPACES = 32,
   parameter int unsigned GAP_SPACES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_en,
   input  logic       rail_pos,
   input  logic       rail_neg,
   input  logic       ami_sel,
   input  logic       relax_sel,
   input  logic       rd_stb,
   output logic [7:0] status
);
   localparam int unsigned CNT_W = $clog2(LOS_SPACES + 1);

   if (GAP_SPACES == 0 || GAP_SPACES >= LOS_SPACES) begin : g_bad_gap
      $error("lcv_monitor: GAP_SPACES out of range");
   end

   logic              is_mark;
   logic [CNT_W-1:0]  run_len;
   logic              gap_ok;
   logic              z4_ev, los_q, los_chg, lcv_ev, sig_ev;
   logic [EV_NUM-1:0] ev, flags;
   lcv_rule_e         rule;

   assign is_mark = rail_pos ^ rail_neg;
   assign gap_ok  = run_len >= CNT_W'(GAP_SPACES);
   assign rule    = ami_sel ? RULE_AMI : (relax_sel ? RULE_RELAX : RULE_HDB3);

   lcv_space_run #(
      .ZERO_RUN  (ZERO_RUN),
      .LOS_SPACES(LOS_SPACES)
   ) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (sample_en),
      .is_mark(is_mark),
      .run_len(run_len),
      .z4_ev  (z4_ev),
      .los_q  (los_q),
      .los_chg(los_chg)
   );

   lcv_polarity_track u_pol (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (sample_en),
      .is_mark (is_mark),
      .mark_pos(rail_pos),
      .gap_ok  (gap_ok),
      .rule    (rule),
      .lcv_ev  (lcv_ev),
      .sig_ev  (sig_ev)
   );

   always_comb begin
      ev         = '0;
      ev[EV_LCV] = lcv_ev;
      ev[EV_LOS] = los_chg;
      ev[EV_SIG] = sig_ev;
      ev[EV_Z4]  = z4_ev;
   end

   lcv_status_latch #(.NUM_EV(EV_NUM)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_stb(rd_stb),
      .ev    (ev),
      .flags (flags)
   );

   assign status = {flags[EV_LCV], flags[EV_LOS], flags[EV_SIG], flags[EV_Z4],
                    3'b000, los_q};

   assert_los_change_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (los_q != $past(los_q)) |-> status[6]);
   assert_level_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] == los_q);
endmodule

// File: tb/sim_lcv_monitor.sv
module sim_lcv_monitor;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b0;
   logic       rail_pos = 1'b0;
   logic       rail_neg = 1'b0;
   logic       ami_sel = 1'b0;
   logic       relax_sel = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] status;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcv_monitor u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .rail_pos (rail_pos),
      .rail_neg (rail_neg),
      .ami_sel  (ami_sel),
      .relax_sel(relax_sel),
      .rd_stb   (rd_stb),
      .status   (status)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
      end
   endtask

   task automatic do_reset(input logic ami, input logic relax);
      @(negedge clk);
      rst_n = 1'b0; sample_en = 1'b0; rail_pos = 1'b0; rail_neg = 1'b0;
      rd_stb = 1'b0; ami_sel = ami; relax_sel = relax;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one enabled sample; returns at the negedge after the latching edge
   task automatic send(input logic p, input logic n);
      @(negedge clk);
      rail_pos = p; rail_neg = n; sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0; rail_pos = 1'b0; rail_neg = 1'b0;
   endtask

   task automatic spaces(input int k);
      for (int i = 0; i < k; i++) send(1'b0, 1'b0);
   endtask

   task automatic read_status(output logic [7:0] v);
      @(negedge clk);
      v = status;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(1'b1, 1'b0);
      check("R1", "reset value", status, 8'h00);
   endtask

   task automatic t_ami();
      logic [7:0] v;
      do_reset(1'b1, 1'b0);
      send(1, 0);
      check("R9", "first mark quiet", status, 8'h00);
      spaces(1); send(0, 1); spaces(1); send(1, 0);
      read_status(v);
      check("R3", "alternating marks", v, 8'h00);
      send(1, 0);
      read_status(v);
      check("R3", "repeated positive", v, 8'h80);
      check("R2", "cleared after read", status, 8'h00);
   endtask

   task automatic t_hdb3();
      logic [7:0] v;
      do_reset(1'b0, 1'b0);
      send(1, 0); spaces(2); send(1, 0);
      check("R9", "first violation quiet", status, 8'h00);
      send(0, 1); spaces(2); send(0, 1);
      read_status(v);
      check("R6", "valid substitution", v, 8'h20);
      send(1, 0); spaces(1); send(1, 0);
      read_status(v);
      check("R4", "one space before violation", v, 8'h80);
      spaces(2); send(1, 0);
      read_status(v);
      check("R4", "same polarity violation", v, 8'h80);
   endtask

   task automatic t_relax();
      logic [7:0] v;
      do_reset(1'b0, 1'b1);
      send(1, 0); spaces(2); send(1, 0);
      send(0, 1); send(0, 1);
      read_status(v);
      check("R5", "alternating violations no gap", v, 8'h00);
      send(1, 0); send(1, 0);
      send(1, 0);
      read_status(v);
      check("R5", "same polarity violations", v, 8'h80);
   endtask

   task automatic t_zeros();
      logic [7:0] v;
      do_reset(1'b0, 1'b0);
      send(1, 0);
      spaces(3);
      check("R7", "three spaces", status, 8'h00);
      spaces(1);
      read_status(v);
      check("R7", "fourth space", v, 8'h10);
      spaces(1);
      check("R7", "fifth space no repeat", status, 8'h00);
      spaces(26);
      check("R8", "31 spaces", status, 8'h00);
      spaces(1);
      read_status(v);
      check("R8", "32nd space raises loss", v, 8'h41);
      check("R8", "level held after read", status, 8'h01);
      send(1, 0);
      check("R8", "mark ends loss", status, 8'h40);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      do_reset(1'b1, 1'b0);
      send(1, 0);
      @(negedge clk);
      rail_pos = 1'b1; sample_en = 1'b1; rd_stb = 1'b1;
      @(negedge clk);
      rail_pos = 1'b0; sample_en = 1'b0; rd_stb = 1'b0;
      check("R2", "event during read kept", status, 8'h80);
      read_status(v);
      check("R2", "later read clears", status, 8'h00);
   endtask

   task automatic t_both_rails();
      logic [7:0] v;
      do_reset(1'b1, 1'b0);
      send(1, 0); send(1, 1);
      check("R10", "both rails no event", status, 8'h00);
      send(1, 0);
      read_status(v);
      check("R10", "history kept across both-rails", v, 8'h80);
   endtask

   task automatic t_disabled();
      do_reset(1'b1, 1'b0);
      send(1, 0);
      @(negedge clk);
      rail_pos = 1'b1; sample_en = 1'b0;
      repeat (6) @(negedge clk);
      rail_pos = 1'b0;
      check("R11", "disabled marks ignored", status, 8'h00);
      send(0, 1);
      check("R11", "no event from hidden repeat", status, 8'h00);
   endtask

   initial begin
      t_reset();
      t_ami();
      t_hdb3();
      t_relax();
      t_zeros();
      t_collision();
      t_both_rails();
      t_disabled();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule